// File: doc/BRIEF.md
# Idle-Locked Serial Stream Descrambler

This block recovers plain data from a scrambled serial bit stream arriving one bit per clock, qualified by a bit-valid strobe. It generates its key stream locally with an 11-bit linear feedback shift register using the polynomial x^11 + x^9 + 1. Each output bit is the received bit XORed with the key bit for that bit time. The register is never seeded from outside. It is trained from the line while the far end sends idle, which is all ones before scrambling, so each received bit complemented is the key bit.

After lock the register runs freely. A hold timer, counted in accepted bits, confirms that lock still holds. The timer is reloaded each time a run of idle ones appears in the descrambled stream. If the timer runs out, the block drops lock and starts acquisition again. Output is unaligned: one bit per accepted input bit, with one clock of latency. A bypass input passes the raw stream straight to the output.

Top module: `idle_lock_descrambler`

## Requirements
- R1: After synchronous reset, `locked` and `out_valid` are low.
- R2: While unlocked, the block loads each accepted bit, complemented, into the key register. The first 11 accepted bits only fill the register. After that, each accepted bit is checked against the key the register predicts, and a mismatch restarts the count. `locked` rises on the clock edge that accepts the 60th consecutive matching bit, so from reset an idle stream locks on its 71st bit. No bit accepted while unlocked produces `out_valid`.
- R3: A bit accepted while `locked` is high produces `out_valid` high on the next clock. On that clock `out_bit` equals the received bit XOR the key bit, and the key bit is the XOR of register taps 11 and 9.
- R4: A clock with `in_valid` low leaves the key register, the counters and the timer unchanged, and gives `out_valid` low on the next clock.
- R5: On lock, and on each refresh, the hold timer loads `HOLD_BITS`. If `HOLD_BITS` accepted bits then follow with no refresh, `locked` falls on the edge that accepts the last of them. That last bit is still output as valid.
- R6: While locked, 58 consecutive descrambled ones form a refresh, which reloads the hold timer. The run count then restarts from zero.
- R7: After dropping lock, the block refills the register from scratch. An idle stream then relocks on its 71st accepted bit, and descrambling resumes correctly.
- R8: While `bypass` is high, an accepted bit appears unchanged on `out_bit` one clock later, with `out_valid` high, whatever the lock state. Bypass does not disturb key tracking or the hold timer, so descrambling is correct as soon as bypass is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_bit` for this clock |
| in_bit | input | 1 | Scrambled NRZ bit |
| bypass | input | 1 | Pass the raw stream to the output |
| out_valid | output | 1 | Qualifies `out_bit` |
| out_bit | output | 1 | Descrambled (or bypassed) bit |
| locked | output | 1 | Key register is synchronized |

## Verification
The hardest state to reach from the ports is the refresh path. A refresh has to land while the timer is low but not yet expired, and the timer must still run out exactly `HOLD_BITS` bits after the refresh. The stimulus starts from a known lock point and uses a shortened timer. It sends a data pattern with a zero every 16 bits, so no idle run can form by accident, until only a few counts remain. It then sends exactly 58 ones and resumes the data pattern. Lock must survive past the original deadline and then fall on the exact bit `HOLD_BITS` after the refresh. Relock, bypass and gaps in `in_valid` are then exercised against the same reference key stream.

// File: rtl/desc_pkg.sv
package desc_pkg;
    localparam int KEY_W = 11;
    localparam int TAP_HI = 10;   // polynomial term x^11
    localparam int TAP_LO = 8;    // polynomial term x^9
    localparam int CODE_BITS = 5;
    localparam int LOCK_GROUPS = 12;
    localparam int LOCK_RUN = CODE_BITS * LOCK_GROUPS;   // 60 descrambled ones
    localparam int REFRESH_RUN = 58;

    typedef logic [KEY_W-1:0] key_reg_t;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } sync_state_e;

    typedef struct packed {
        logic valid;
        logic data;
    } bit_beat_t;

    function automatic logic next_key(input key_reg_t r);
        return r[TAP_HI] ^ r[TAP_LO];
    endfunction
endpackage

// File: rtl/desc_keygen.sv
module desc_keygen
    import desc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic train,
    input  logic rx_bit,
    output logic key_bit,
    output logic predict_ok
);
    key_reg_t kreg;

    assign key_bit    = next_key(kreg);
    assign predict_ok = (key_bit == ~rx_bit);

    always_ff @(posedge clk) begin
        if (rst) begin
            kreg <= '0;
        end else if (adv) begin
            kreg <= {kreg[KEY_W-2:0], train ? ~rx_bit : key_bit};
        end
    end

    assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(kreg));
endmodule

// File: rtl/desc_lockmon.sv
module desc_lockmon
    import desc_pkg::*;
#(
    parameter int HOLD_BITS = 90250,
    parameter int FILL_BITS = KEY_W,
    parameter int ACQ_RUN = LOCK_RUN,
    parameter int REF_RUN = REFRESH_RUN
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic predict_ok,
    input  logic plain_bit,
    output logic locked
);
    localparam int FW = $clog2(FILL_BITS + 1);
    localparam int MW = $clog2(ACQ_RUN + 1);
    localparam int RW = $clog2(REF_RUN + 1);
    localparam int TW = $clog2(HOLD_BITS + 1);

    sync_state_e   state;
    logic [FW-1:0] fill_cnt;
    logic [MW-1:0] match_cnt;
    logic [RW-1:0] run_cnt;
    logic [TW-1:0] timer;
    logic          refresh;

    assign locked  = (state == ST_LOCK);
    assign refresh = locked && adv && plain_bit && (run_cnt == RW'(REF_RUN - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_HUNT;
            fill_cnt  <= '0;
            match_cnt <= '0;
            run_cnt   <= '0;
            timer     <= '0;
        end else if (adv) begin
            case (state)
                ST_HUNT: begin
                    if (fill_cnt != FW'(FILL_BITS)) begin
                        fill_cnt <= fill_cnt + 1'b1;
                    end else if (!predict_ok) begin
                        match_cnt <= '0;
                    end else if (match_cnt == MW'(ACQ_RUN - 1)) begin
                        state     <= ST_LOCK;
                        match_cnt <= '0;
                        run_cnt   <= '0;
                        timer     <= TW'(HOLD_BITS);
                    end else begin
                        match_cnt <= match_cnt + 1'b1;
                    end
                end
                default: begin
                    if (refresh) begin
                        timer   <= TW'(HOLD_BITS);
                        run_cnt <= '0;
                    end else if (timer == TW'(1)) begin
                        state     <= ST_HUNT;
                        fill_cnt  <= '0;
                        match_cnt <= '0;
                        run_cnt   <= '0;
                        timer     <= '0;
                    end else begin
                        timer   <= timer - 1'b1;
                        run_cnt <= plain_bit ? run_cnt + 1'b1 : '0;
                    end
                end
            endcase
        end
    end

    assert_lock_after_run_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> ($past(match_cnt) == MW'(ACQ_RUN - 1)) && ($past(fill_cnt) == FW'(FILL_BITS)));
    assert_drop_on_expiry_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> $past(adv) && ($past(timer) == TW'(1)));
    assert_refresh_reload_R6: assert property (@(posedge clk) disable iff (rst)
        refresh |=> locked && (timer == TW'(HOLD_BITS)) && (run_cnt == '0));
    assert_timer_idle_R4: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(timer) && $stable(state));
endmodule

// File: rtl/idle_lock_descrambler.sv
module idle_lock_descrambler
    import desc_pkg::*;
#(
    parameter int HOLD_BITS = 90250
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_bit,
    input  logic bypass,
    output logic out_valid,
    output logic out_bit,
    output logic locked
);
    logic      key_bit;
    logic      predict_ok;
    logic      plain_bit;
    bit_beat_t out_q;

    desc_keygen u_keygen (
        .clk        (clk),
        .rst        (rst),
        .adv        (in_valid),
        .train      (!locked),
        .rx_bit     (in_bit),
        .key_bit    (key_bit),
        .predict_ok (predict_ok)
    );

    assign plain_bit = in_bit ^ key_bit;

    desc_lockmon #(.HOLD_BITS(HOLD_BITS)) u_lockmon (
        .clk        (clk),
        .rst        (rst),
        .adv        (in_valid),
        .predict_ok (predict_ok),
        .plain_bit  (plain_bit),
        .locked     (locked)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.valid <= in_valid && (bypass || locked);
            out_q.data  <= bypass ? in_bit : plain_bit;
        end
    end

    assign out_valid = out_q.valid;
    assign out_bit   = out_q.data;

    assert_valid_needs_lock_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid) && ($past(locked) || $past(bypass)));
    assert_gap_no_output_R4: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_bypass_raw_R8: assert property (@(posedge clk) disable iff (rst)
        (bypass && in_valid) |=> out_valid && (out_bit == $past(in_bit)));
endmodule

// File: tb/idle_lock_descrambler_bench.sv
module idle_lock_descrambler_bench;
    localparam int HOLD = 200;

    typedef struct {
        bit    v;
        bit    d;
        bit    lk;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic bypass = 1'b0;
    logic out_valid, out_bit, locked;

    int checks = 0;
    int failures = 0;
    exp_t sb[$];
    logic [10:0] ref_s = 11'h5A3;
    bit lk_model = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    idle_lock_descrambler #(.HOLD_BITS(HOLD)) u_idle_lock_descrambler (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
        .bypass(bypass), .out_valid(out_valid), .out_bit(out_bit), .locked(locked)
    );

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // drive one accepted bit: plain value ud, expected lock after this edge
    task automatic send(input bit ud, input bit lk_after, input bit byp, input string tag);
        bit k;
        bit sd;
        exp_t e;
        @(negedge clk);
        k = ref_s[10] ^ ref_s[8];
        ref_s = {ref_s[9:0], k};
        sd = ud ^ k;
        in_valid = 1'b1;
        in_bit = sd;
        bypass = byp;
        e.v = byp ? 1'b1 : lk_model;
        e.d = byp ? sd : ud;
        e.lk = lk_after;
        e.tag = tag;
        lk_model = lk_after;
        sb.push_back(e);
    endtask

    task automatic gap(input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b0;
        in_bit = 1'b1;
        e.v = 1'b0;
        e.d = 1'b0;
        e.lk = lk_model;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(out_valid == e.v, e.tag, "out_valid", out_valid, e.v);
                check(locked == e.lk, e.tag, "locked", locked, e.lk);
                if (e.v) check(out_bit == e.d, e.tag, "out_bit", out_bit, e.d);
            end
        end
    end

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(locked == 1'b0, "R1", "locked after reset", locked, 0);
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

        // R2: 71 idle bits from reset; lock on the last; one gap (R4)
        for (int j = 0; j < 71; j++) begin
            send(1'b1, j == 70, 1'b0, "R2");
            if (j == 30) gap("R4");
        end
        // R3: data with a zero every 16 bits, 129 bits, ends on a zero
        for (int j = 0; j < 129; j++) begin
            send(j % 16 != 0, 1'b1, 1'b0, "R3");
            if (j % 9 == 4) gap("R4");
        end
        // R6: exactly 58 ones refresh the timer (timer is at 14 when it lands)
        for (int j = 0; j < 58; j++) send(1'b1, 1'b1, 1'b0, "R6");
        // R5: HOLD bits after refresh, lock drops on the last one
        for (int j = 0; j < HOLD; j++) begin
            send(j % 16 != 0, j != HOLD - 1, 1'b0, "R5");
            if (j == 100) gap("R4");
        end
        // R7: relock from a fresh fill
        for (int j = 0; j < 71; j++) send(1'b1, j == 70, 1'b0, "R7");
        for (int j = 0; j < 40; j++) send(j % 5 != 2, 1'b1, 1'b0, "R7");
        // R8: bypass passes raw bits, then descrambling continues aligned
        for (int j = 0; j < 20; j++) send(j % 3 == 0, 1'b1, 1'b1, "R8");
        for (int j = 0; j < 20; j++) send(j % 4 != 1, 1'b1, 1'b0, "R8");
        gap("R4");
        gap("R4");
        @(negedge clk);
        @(negedge clk);
        check(sb.size() == 0, "R3", "scoreboard drained", sb.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule